// File: doc/BRIEF.md
# Segment translation unit

This block converts a logical address, made of a segment number and an offset inside that segment, into a physical address. Segment descriptors live in a table in memory. A table base input gives the table's location, and a table length input gives how many segments the table holds. For each accepted request the unit first checks the segment number against the table length. When that check fails, the unit raises a trap at once and reads nothing from memory. Otherwise it fetches the segment's two-word descriptor through a read port that allows one outstanding access, checks the descriptor, and returns either the physical address or a trap cause.

A descriptor occupies two consecutive words of `ADDR_W` bits. The first word is the segment's physical start address. The second word holds the segment length in its upper `ADDR_W-4` bits and four flag bits in bits 3:0: bit 3 marks the descriptor as present, bit 2 allows reads, bit 1 allows writes and bit 0 allows execution. The unit accepts a new request only while it is idle, and every request operand is captured at acceptance.

Top module: `seg_xlate`

## Requirements
- R1: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while no translation is in progress, and it stays low from acceptance until the result is produced. The segment number, offset, access type, table base and table length are all sampled at acceptance, so later changes on those inputs have no effect on the translation.
- R2: When the segment number is greater than or equal to `tbl_len_i`, `done_o` goes high in the cycle after acceptance with `trap_o`=1 and `cause_o`=2'b00, and no memory read is issued.
- R3: For a segment in range, the unit issues two reads in sequence. The first is at `tbl_base_i + 8*seg` (for `ADDR_W`=32) and the second is 4 bytes higher. Each `mem_req_o` is a one-cycle pulse, and the second read is issued only after the first response has arrived.
- R4: A descriptor whose present bit (second word, bit 3) is 0 traps with `cause_o`=2'b01.
- R5: An offset greater than or equal to the segment length (second word, bits 31:4) traps with `cause_o`=2'b10.
- R6: The access type selects the flag bit that must be set: 2'b00 (read) needs bit 2, 2'b01 (write) needs bit 1 and 2'b10 (execute) needs bit 0. Type 2'b11 is never permitted. A missing permission traps with `cause_o`=2'b11.
- R7: When several checks fail, the cause reported is the first failing check in this order: segment range, present bit, length bound, permission.
- R8: A legal access returns `paddr_o` equal to the segment start plus the offset, modulo 2^`ADDR_W`, with `trap_o`=0 and `cause_o`=2'b00.
- R9: `done_o` is a one-cycle pulse that rises in the cycle after the cycle in which the second descriptor word is returned. `trap_o`, `cause_o` and `paddr_o` are valid while `done_o` is high and are zero otherwise. On a trap, `paddr_o` is 0.
- R10: A `mem_rvalid_i` pulse that arrives while no read is outstanding is ignored. It produces no `done_o`, and it does not alter the next translation.
- R11: While reset is asserted, `req_ready_o` is high and `done_o`, `trap_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Unit idle, request can be accepted |
| req_seg_i | input | SEG_W | Segment number |
| req_off_i | input | ADDR_W-4 | Offset inside the segment |
| req_acc_i | input | 2 | Access type: 00 read, 01 write, 10 execute |
| tbl_base_i | input | ADDR_W | Byte address of descriptor table |
| tbl_len_i | input | SEG_W+1 | Number of segments in the table |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | ADDR_W | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | ADDR_W | Read data |
| done_o | output | 1 | Result pulse |
| trap_o | output | 1 | Translation refused |
| cause_o | output | 2 | Trap cause code |
| paddr_o | output | ADDR_W | Physical address |

## Verification
On every cycle, the assertions check the memory port discipline: reads are single pulses, only one read is outstanding at a time, the first read address is derived from the table base and the segment number, and no read is issued while the unit is idle. They also check that an out-of-range segment traps in the next cycle without any read, and that the trap and address outputs are qualified by `done_o`. The descriptor checks themselves can only be shown by the bench's scenarios, because they depend on descriptor contents that no port carries at the time of the result. These are the present bit, the length bound, the permission selection, the priority between simultaneous failures and the wrapping addition. The bench also covers spurious read responses and input changes after acceptance.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int unsigned FLAG_W = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    TRAP_RANGE   = 2'b00,
    TRAP_ABSENT  = 2'b01,
    TRAP_BOUND   = 2'b10,
    TRAP_PERM    = 2'b11
  } trap_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISS0,
    ST_WT0,
    ST_ISS1,
    ST_WT1
  } st_e;

  // bit order matches descriptor word 1 bits 3:0
  typedef struct packed {
    logic present;
    logic rd;
    logic wr;
    logic ex;
  } flags_t;

endpackage

// File: rtl/seg_xlate_fsm.sv
module seg_xlate_fsm
  import seg_xlate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic in_range_i,
  input  logic mem_rvalid_i,
  output logic ready_o,
  output logic mem_req_o,
  output logic word_sel_o,
  output logic w0_en_o,
  output logic fin_o,
  output logic range_trap_o
);

  st_e st_q, st_d;

  always_comb begin
    st_d         = st_q;
    ready_o      = 1'b0;
    mem_req_o    = 1'b0;
    word_sel_o   = 1'b0;
    w0_en_o      = 1'b0;
    fin_o        = 1'b0;
    range_trap_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        ready_o = 1'b1;
        if (req_valid_i) begin
          if (in_range_i) st_d = ST_ISS0;
          else            range_trap_o = 1'b1;
        end
      end
      ST_ISS0: begin
        mem_req_o = 1'b1;
        st_d      = ST_WT0;
      end
      ST_WT0: begin
        if (mem_rvalid_i) begin
          w0_en_o = 1'b1;
          st_d    = ST_ISS1;
        end
      end
      ST_ISS1: begin
        mem_req_o  = 1'b1;
        word_sel_o = 1'b1;
        st_d       = ST_WT1;
      end
      ST_WT1: begin
        word_sel_o = 1'b1;
        if (mem_rvalid_i) begin
          fin_o = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/seg_desc_eval.sv
module seg_desc_eval
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LIM_W = ADDR_W - FLAG_W
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] attr_i,
  input  logic [LIM_W-1:0]  off_i,
  input  logic [1:0]        acc_i,
  output logic              trap_o,
  output logic [1:0]        cause_o,
  output logic [ADDR_W-1:0] paddr_o
);

  flags_t           flags;
  logic [LIM_W-1:0] limit;
  logic             perm_ok;
  logic             bound_ok;

  assign flags    = flags_t'(attr_i[FLAG_W-1:0]);
  assign limit    = attr_i[ADDR_W-1:FLAG_W];
  assign bound_ok = off_i < limit;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  perm_ok = flags.rd;
      ACC_WRITE: perm_ok = flags.wr;
      ACC_EXEC:  perm_ok = flags.ex;
      default:   perm_ok = 1'b0;
    endcase
  end

  // checks in fixed priority; range check is done before the fetch
  always_comb begin
    trap_o  = 1'b1;
    cause_o = TRAP_RANGE;
    paddr_o = '0;
    if (!flags.present)  cause_o = TRAP_ABSENT;
    else if (!bound_ok)  cause_o = TRAP_BOUND;
    else if (!perm_ok)   cause_o = TRAP_PERM;
    else begin
      trap_o  = 1'b0;
      paddr_o = base_i + ADDR_W'(off_i);
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [ADDR_W-5:0] req_off_i,
  input  logic [1:0]        req_acc_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [SEG_W:0]    tbl_len_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              trap_o,
  output logic [1:0]        cause_o,
  output logic [ADDR_W-1:0] paddr_o
);

  localparam int unsigned LIM_W      = ADDR_W - FLAG_W;
  localparam int unsigned WORD_BYTES = ADDR_W / 8;
  localparam int unsigned ENTRY_SH   = $clog2(2 * WORD_BYTES);

  logic              in_range, accept;
  logic              word_sel, w0_en, fin, range_trap;
  logic [ADDR_W-1:0] entry_q, base_q;
  logic [LIM_W-1:0]  off_q;
  logic [1:0]        acc_q;
  logic              ev_trap;
  logic [1:0]        ev_cause;
  logic [ADDR_W-1:0] ev_paddr;
  logic              done_q, trap_q;
  logic [1:0]        cause_q;
  logic [ADDR_W-1:0] paddr_q;

  assign in_range = {1'b0, req_seg_i} < tbl_len_i;
  assign accept   = req_valid_i & req_ready_o;

  seg_xlate_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .in_range_i   (in_range),
    .mem_rvalid_i (mem_rvalid_i),
    .ready_o      (req_ready_o),
    .mem_req_o    (mem_req_o),
    .word_sel_o   (word_sel),
    .w0_en_o      (w0_en),
    .fin_o        (fin),
    .range_trap_o (range_trap)
  );

  // operand capture at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
      off_q   <= '0;
      acc_q   <= '0;
    end else if (accept) begin
      entry_q <= tbl_base_i + (ADDR_W'(req_seg_i) << ENTRY_SH);
      off_q   <= req_off_i;
      acc_q   <= req_acc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    base_q <= '0;
    else if (w0_en) base_q <= mem_rdata_i;
  end

  assign mem_addr_o = word_sel ? entry_q + ADDR_W'(WORD_BYTES) : entry_q;

  // word 1 is evaluated straight off the read bus
  seg_desc_eval #(.ADDR_W(ADDR_W)) u_eval (
    .base_i  (base_q),
    .attr_i  (mem_rdata_i),
    .off_i   (off_q),
    .acc_i   (acc_q),
    .trap_o  (ev_trap),
    .cause_o (ev_cause),
    .paddr_o (ev_paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= '0;
      paddr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= '0;
      paddr_q <= '0;
      if (range_trap) begin
        done_q  <= 1'b1;
        trap_q  <= 1'b1;
        cause_q <= TRAP_RANGE;
      end else if (fin) begin
        done_q  <= 1'b1;
        trap_q  <= ev_trap;
        cause_q <= ev_cause;
        paddr_q <= ev_paddr;
      end
    end
  end

  assign done_o  = done_q;
  assign trap_o  = trap_q;
  assign cause_o = cause_q;
  assign paddr_o = paddr_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEG_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [SEG_W-1:0]  req_seg_i,
  input logic [ADDR_W-1:0] tbl_base_i,
  input logic [SEG_W:0]    tbl_len_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              done_o,
  input logic              trap_o,
  input logic [1:0]        cause_o,
  input logic [ADDR_W-1:0] paddr_o
);

  localparam int unsigned ENTRY_SH = $clog2(2 * (ADDR_W / 8));

  logic              pend_q;
  logic              acc_ok, acc_oor;
  logic [ADDR_W-1:0] want_entry;

  assign acc_ok     = req_valid_i && req_ready_o && ({1'b0, req_seg_i} < tbl_len_i);
  assign acc_oor    = req_valid_i && req_ready_o && ({1'b0, req_seg_i} >= tbl_len_i);
  assign want_entry = tbl_base_i + (ADDR_W'(req_seg_i) << ENTRY_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (mem_req_o)    pend_q <= 1'b1;
    else if (mem_rvalid_i) pend_q <= 1'b0;
  end

  assert_one_outstanding_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q);

  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_first_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok |=> (mem_req_o && mem_addr_o == $past(want_entry)));

  assert_busy_not_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  assert_range_trap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_oor |=> (done_o && trap_o && cause_o == 2'b00 && !mem_req_o));

  assert_trap_qualified_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (done_o && paddr_o == '0));

  assert_quiet_outputs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (cause_o == 2'b00 && paddr_o == '0));

endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_seg_i    (req_seg_i),
  .tbl_base_i   (tbl_base_i),
  .tbl_len_i    (tbl_len_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .done_o       (done_o),
  .trap_o       (trap_o),
  .cause_o      (cause_o),
  .paddr_o      (paddr_o)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [7:0]  req_seg_i = '0;
  logic [27:0] req_off_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic [31:0] tbl_base_i = '0;
  logic [8:0]  tbl_len_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o, trap_o;
  logic [1:0]  cause_o;
  logic [31:0] paddr_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] dw0 [256];
  logic [31:0] dw1 [256];

  always #4 clk_i = ~clk_i;

  seg_xlate i_seg_xlate (.*);

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] w0, input logic [31:0] w1,
                                input logic [27:0] off, input logic [1:0] acc,
                                output logic t, output logic [1:0] c, output logic [31:0] pa);
    logic pok;
    t = 1'b1; c = 2'b00; pa = '0;
    case (acc)
      2'b00:   pok = w1[2];
      2'b01:   pok = w1[1];
      2'b10:   pok = w1[0];
      default: pok = 1'b0;
    endcase
    if (!w1[3])            c = 2'b01;
    else if (off >= w1[31:4]) c = 2'b10;
    else if (!pok)         c = 2'b11;
    else begin t = 1'b0; pa = w0 + {4'b0, off}; end
  endfunction

  // starts and ends at a falling edge
  task automatic xlate(input logic [7:0] seg, input logic [27:0] off, input logic [1:0] acc,
                       input logic [31:0] base, input logic [8:0] len);
    logic        et;
    logic [1:0]  ec;
    logic [31:0] ep;
    logic [31:0] ent;
    model(dw0[seg], dw1[seg], off, acc, et, ec, ep);
    ent = base + {21'b0, seg, 3'b000};
    chk("R1 ready when idle", {31'b0, req_ready_o}, 32'd1);
    req_valid_i = 1'b1; req_seg_i = seg; req_off_i = off; req_acc_i = acc;
    tbl_base_i = base; tbl_len_i = len;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_seg_i = 8'($urandom); req_off_i = 28'($urandom); req_acc_i = 2'($urandom);
    tbl_base_i = $urandom; tbl_len_i = 9'($urandom);
    if ({1'b0, seg} >= len) begin
      chk("R2 done after range fail", {31'b0, done_o}, 32'd1);
      chk("R2 trap", {31'b0, trap_o}, 32'd1);
      chk("R2 cause", {30'b0, cause_o}, 32'd0);
      chk("R2 no read", {31'b0, mem_req_o}, 32'd0);
    end else begin
      for (int k = 0; k < 2; k++) begin
        chk("R3 read issued", {31'b0, mem_req_o}, 32'd1);
        chk("R3 read address", mem_addr_o, k == 0 ? ent : ent + 32'd4);
        chk("R1 busy not ready", {31'b0, req_ready_o}, 32'd0);
        @(negedge clk_i);
        for (int w = 0; w < int'($urandom % 3); w++) begin
          chk("R3 no second read while waiting", {31'b0, mem_req_o}, 32'd0);
          chk("R9 no early done", {31'b0, done_o}, 32'd0);
          @(negedge clk_i);
        end
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = (k == 0) ? dw0[seg] : dw1[seg];
        @(negedge clk_i);
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = $urandom;
      end
      chk("R9 done pulse", {31'b0, done_o}, 32'd1);
      chk("R4 R5 R6 R7 trap flag", {31'b0, trap_o}, {31'b0, et});
      chk("R4 R5 R6 R7 cause", {30'b0, cause_o}, {30'b0, ec});
      chk("R8 physical address", paddr_o, ep);
    end
    @(negedge clk_i);
    chk("R9 done falls", {31'b0, done_o}, 32'd0);
    chk("R9 outputs cleared", paddr_o | {30'b0, cause_o} | {31'b0, trap_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      dw0[i] = $urandom;
      dw1[i] = {28'($urandom % 64), (($urandom % 8) != 0), 3'($urandom)};
    end
    repeat (3) @(negedge clk_i);
    chk("R11 ready in reset", {31'b0, req_ready_o}, 32'd1);
    chk("R11 done low in reset", {31'b0, done_o}, 32'd0);
    chk("R11 trap low in reset", {31'b0, trap_o}, 32'd0);
    chk("R11 no read in reset", {31'b0, mem_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 boundaries: last legal segment, first illegal, empty table
    dw1[9] = {28'd100, 4'b1111};
    xlate(8'd9, 28'd5, 2'b00, 32'h1000_0000, 9'd10);
    xlate(8'd10, 28'd5, 2'b00, 32'h1000_0000, 9'd10);
    xlate(8'd0, 28'd0, 2'b00, 32'h1000_0000, 9'd0);
    dw1[255] = {28'd100, 4'b1111};
    xlate(8'd255, 28'd1, 2'b10, 32'h2000_0040, 9'd256);
    // R7 priority: absent beats bound and perm, bound beats perm
    dw1[3] = {28'd4, 4'b0000};
    xlate(8'd3, 28'd50, 2'b01, 32'h0, 9'd20);
    dw1[4] = {28'd4, 4'b1000};
    xlate(8'd4, 28'd4, 2'b11, 32'h0, 9'd20);
    // R5 bound edge: last byte passes, limit itself fails
    dw1[5] = {28'd16, 4'b1100};
    xlate(8'd5, 28'd15, 2'b00, 32'h0, 9'd20);
    xlate(8'd5, 28'd16, 2'b00, 32'h0, 9'd20);
    // R6 each permission alone, and the never-permitted type
    dw1[6] = {28'd40, 4'b1010};
    xlate(8'd6, 28'd1, 2'b00, 32'h80, 9'd20);
    xlate(8'd6, 28'd1, 2'b01, 32'h80, 9'd20);
    xlate(8'd6, 28'd1, 2'b10, 32'h80, 9'd20);
    dw1[7] = {28'd40, 4'b1111};
    xlate(8'd7, 28'd1, 2'b11, 32'h80, 9'd20);
    // R8 wrap of base plus offset
    dw0[8] = 32'hFFFF_FFF0; dw1[8] = {28'd64, 4'b1111};
    xlate(8'd8, 28'd32, 2'b01, 32'h40, 9'd20);
    // R10 stray response while idle
    mem_rvalid_i = 1'b1; mem_rdata_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    @(negedge clk_i);
    chk("R10 stray response makes no done", {31'b0, done_o}, 32'd0);
    xlate(8'd7, 28'd2, 2'b00, 32'h80, 9'd20);

    for (int n = 0; n < 400; n++) begin
      logic [7:0]  s = 8'($urandom);
      logic [27:0] o = ($urandom % 2) ? 28'($urandom % 70) : 28'($urandom);
      logic [8:0]  l = ($urandom % 4 == 0) ? 9'($urandom % 257) : 9'(200 + $urandom % 57);
      xlate(s, o, 2'($urandom), {$urandom} & 32'hFFFF_FFF8, l);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule